// File: doc/BRIEF.md
# Event Queue Enqueue and Notify Engine

This block turns an incoming event trigger into a record in a circular queue held in system memory and then decides whether a downstream notification is due. A trigger names one entry of a small on-chip descriptor table and carries a 32-bit data word. The engine reads that descriptor, forms the ring address from the descriptor's base and current index, and issues one 32-bit memory write whose top bit is the ring's current generation bit. Once the write has been acknowledged, it stores the advanced index and generation back into the descriptor.

The generation bit flips every time the index wraps to zero. This lets a consumer tell fresh entries from stale ones without a shared head pointer. After the enqueue step, the descriptor's valid, format, priority and notify fields decide whether a notification pulse goes out, tagged with the descriptor index. The table is loaded and inspected one 32-bit word at a time through a plain word port. A single request/acknowledge port with an error flag carries the queue write.

Descriptor layout: word 0 holds valid (bit 31), enqueue (bit 30), notify (bit 29) and the size exponent (bits 3:0). Word 1 holds the generation (bit 31) and the index (bits 27:0). Word 2 holds the upper base address (bits 27:0) and word 3 the lower base address. Word 6 holds the format (bit 31) and word 7 the priority (bits 7:0).

Top module: `evq_enqueue_engine`

## Requirements
- R1: The write address equals {word2[27:0], word3} plus four times the index in word1[27:0], presented on a 60-bit address.
- R2: The written entry carries the generation bit word1[31] in bit 31 and bits 30:0 of the trigger data in bits 30:0.
- R3: After a successful write, word1[27:0] becomes (index + 1) modulo 2^(word0[3:0] + 10), and word1 bits 30:28 are kept.
- R4: The generation bit word1[31] is inverted exactly when the advanced index wraps to zero.
- R5: A trigger on a descriptor whose valid bit word0[31] is clear causes no memory request, no notification and no descriptor change.
- R6: With the enqueue bit word0[30] clear, no memory request is made and word1 is left unchanged, but notification is still evaluated.
- R7: With format word6[31] clear and priority word7[7:0] equal to 0xFF, no notification is raised. With the format bit set, the same priority does not suppress notification.
- R8: Notification is raised only when the notify bit word0[29] is set. When it is raised, notify_o pulses for one cycle with notify_desc_o equal to the triggered index.
- R9: busy_o is high from the cycle after a trigger is accepted until processing ends. While it is high, trig_ready_o is low and further triggers are ignored.
- R10: An acknowledge flagged with mem_err_i leaves word1 unchanged, pulses err_o in the acknowledge cycle, and ends processing with no notification.
- R11: mem_req_o stays high with stable address and data until mem_ack_i is seen.
- R12: After reset, the engine is idle and ready, raises no request or notification, and all descriptor words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_valid_i | input | 1 | Event trigger present |
| trig_ready_o | output | 1 | Engine can accept a trigger |
| trig_desc_i | input | IDX_W | Descriptor index of the trigger |
| trig_data_i | input | 32 | Event data word |
| busy_o | output | 1 | Trigger being processed |
| tbl_we_i | input | 1 | Descriptor word write strobe |
| tbl_idx_i | input | IDX_W | Descriptor index for table access |
| tbl_word_i | input | 3 | Word number within the descriptor |
| tbl_wdata_i | input | 32 | Descriptor word write data |
| tbl_rdata_o | output | 32 | Descriptor word read data |
| mem_req_o | output | 1 | Queue write request |
| mem_addr_o | output | 60 | Queue write byte address |
| mem_wdata_o | output | 32 | Queue entry word |
| mem_ack_i | input | 1 | Write response |
| mem_err_i | input | 1 | Response reports an error |
| notify_o | output | 1 | Notification pulse |
| notify_desc_o | output | IDX_W | Descriptor index of the notification |
| err_o | output | 1 | Write error pulse |

## Verification
The descriptor lookup happens in the first cycle after the accepting edge, and the memory request appears in the cycle after that. Writeback lands on the edge after the acknowledging edge, and the notification pulse follows one cycle later, or one cycle after lookup when no enqueue is made. err_o rises in the acknowledge cycle itself. The bench steps one falling edge at a time from acceptance: it drives the acknowledge at the falling edge and samples err_o shortly after, records request, notify and busy at each step, and reads descriptor words back only once busy has dropped.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int WORD_W    = 32;
  localparam int WORDS     = 8;
  localparam int WSEL_W    = 3;
  localparam int QIDX_W    = 28;
  localparam int BASE_HI_W = 28;
  localparam int ADDR_W    = BASE_HI_W + WORD_W;
  localparam int QSIZE_W   = 4;
  localparam int QSIZE_OFS = 10;
  localparam int PRIO_W    = 8;
  localparam int VALID_BIT = 31;
  localparam int ENQ_BIT   = 30;
  localparam int NTF_BIT   = 29;
  localparam int GEN_BIT   = 31;
  localparam int FMT_BIT   = 31;

  typedef logic [WORDS-1:0][WORD_W-1:0] desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_WB,
    ST_NOTE
  } eng_state_e;
endpackage

// File: rtl/evq_desc_table.sv
module evq_desc_table
  import evq_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [WSEL_W-1:0] ext_word,
  input  logic [WORD_W-1:0] ext_wdata,
  output logic [WORD_W-1:0] ext_rdata,
  input  logic [IDX_W-1:0]  eng_idx,
  output desc_t             eng_desc,
  input  logic              wb_en,
  input  logic [WORD_W-1:0] wb_word1
);
  desc_t store_q [NUM_DESC];

  // engine writeback is placed last so it wins over a same-cycle port write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DESC; d++) begin
        store_q[d] <= '0;
      end
    end else begin
      if (ext_we) begin
        store_q[ext_idx][ext_word] <= ext_wdata;
      end
      if (wb_en) begin
        store_q[eng_idx][1] <= wb_word1;
      end
    end
  end

  assign ext_rdata = store_q[ext_idx][ext_word];
  assign eng_desc  = store_q[eng_idx];
endmodule

// File: rtl/evq_ring_calc.sv
module evq_ring_calc
  import evq_pkg::*;
(
  input  desc_t             desc,
  input  logic [WORD_W-1:0] data,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] entry,
  output logic [WORD_W-1:0] word1_next
);
  logic [ADDR_W-1:0]  base;
  logic [QIDX_W-1:0]  cur_idx;
  logic [QIDX_W-1:0]  nxt_idx;
  logic [QIDX_W-1:0]  idx_mask;
  logic [QIDX_W:0]    span;
  logic [QIDX_W:0]    span_m1;
  logic [QSIZE_W:0]   shamt;
  logic               gen;
  logic               wrap;
  logic               unused_bits;

  always_comb begin
    base     = {desc[2][BASE_HI_W-1:0], desc[3]};
    cur_idx  = desc[1][QIDX_W-1:0];
    gen      = desc[1][GEN_BIT];
    shamt    = {1'b0, desc[0][QSIZE_W-1:0]} + (QSIZE_W+1)'(QSIZE_OFS);
    span     = {{QIDX_W{1'b0}}, 1'b1} << shamt;
    span_m1  = span - 1'b1;
    idx_mask = span_m1[QIDX_W-1:0];
    nxt_idx  = (cur_idx + QIDX_W'(1)) & idx_mask;
    wrap     = (nxt_idx == '0);
    addr     = base + ADDR_W'({cur_idx, 2'b00});
    entry    = {gen, data[WORD_W-2:0]};
    word1_next                = desc[1];
    word1_next[GEN_BIT]       = gen ^ wrap;
    word1_next[QIDX_W-1:0]    = nxt_idx;
  end

  assign unused_bits = ^{desc[7:4], desc[0][WORD_W-1:QSIZE_W],
                         desc[2][WORD_W-1:BASE_HI_W], data[WORD_W-1]};
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [IDX_W-1:0]  trig_desc,
  input  logic [WORD_W-1:0] trig_data,
  output logic              trig_ready,
  output logic              busy,
  input  logic              desc_valid,
  input  logic              desc_enq,
  input  logic              desc_ntf,
  input  logic              desc_fmt,
  input  logic [PRIO_W-1:0] desc_prio,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [WORD_W-1:0] cur_data,
  output logic              mem_req,
  output logic              wb_en,
  output logic              notify,
  output logic              err
);
  eng_state_e state_q, state_d;
  logic       accept;
  logic       masked;

  assign accept = trig_valid && (state_q == ST_IDLE);
  assign masked = !desc_fmt && (desc_prio == {PRIO_W{1'b1}});

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOOK;
      ST_LOOK: begin
        if (!desc_valid)   state_d = ST_IDLE;
        else if (desc_enq) state_d = ST_REQ;
        else               state_d = ST_NOTE;
      end
      ST_REQ:  if (mem_ack) state_d = mem_err ? ST_IDLE : ST_WB;
      ST_WB:   state_d = ST_NOTE;
      ST_NOTE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_data <= '0;
    end else if (accept) begin
      cur_idx  <= trig_desc;
      cur_data <= trig_data;
    end
  end

  assign trig_ready = (state_q == ST_IDLE);
  assign busy       = !trig_ready;
  assign mem_req    = (state_q == ST_REQ);
  assign wb_en      = (state_q == ST_WB);
  assign err        = mem_req && mem_ack && mem_err;
  assign notify     = (state_q == ST_NOTE) && desc_ntf && !masked;
endmodule

// File: rtl/evq_enqueue_engine.sv
module evq_enqueue_engine
  import evq_pkg::*;
#(
  parameter  int NUM_DESC = 8,
  localparam int IDX_W    = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid_i,
  output logic              trig_ready_o,
  input  logic [IDX_W-1:0]  trig_desc_i,
  input  logic [31:0]       trig_data_i,
  output logic              busy_o,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic [2:0]        tbl_word_i,
  input  logic [31:0]       tbl_wdata_i,
  output logic [31:0]       tbl_rdata_o,
  output logic              mem_req_o,
  output logic [59:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic              notify_o,
  output logic [IDX_W-1:0]  notify_desc_o,
  output logic              err_o
);
  logic              rst_meta, rst_sync;
  desc_t             eng_desc;
  logic [IDX_W-1:0]  cur_idx;
  logic [WORD_W-1:0] cur_data;
  logic [WORD_W-1:0] word1_next;
  logic              wb_en;
  logic              unused_top;

  // reset asserts at once and leaves two clock edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  evq_desc_table #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ext_we    (tbl_we_i),
    .ext_idx   (tbl_idx_i),
    .ext_word  (tbl_word_i),
    .ext_wdata (tbl_wdata_i),
    .ext_rdata (tbl_rdata_o),
    .eng_idx   (cur_idx),
    .eng_desc  (eng_desc),
    .wb_en     (wb_en),
    .wb_word1  (word1_next)
  );

  evq_ring_calc u_ring (
    .desc       (eng_desc),
    .data       (cur_data),
    .addr       (mem_addr_o),
    .entry      (mem_wdata_o),
    .word1_next (word1_next)
  );

  evq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync),
    .trig_valid (trig_valid_i),
    .trig_desc  (trig_desc_i),
    .trig_data  (trig_data_i),
    .trig_ready (trig_ready_o),
    .busy       (busy_o),
    .desc_valid (eng_desc[0][VALID_BIT]),
    .desc_enq   (eng_desc[0][ENQ_BIT]),
    .desc_ntf   (eng_desc[0][NTF_BIT]),
    .desc_fmt   (eng_desc[6][FMT_BIT]),
    .desc_prio  (eng_desc[7][PRIO_W-1:0]),
    .mem_ack    (mem_ack_i),
    .mem_err    (mem_err_i),
    .cur_idx    (cur_idx),
    .cur_data   (cur_data),
    .mem_req    (mem_req_o),
    .wb_en      (wb_en),
    .notify     (notify_o),
    .err        (err_o)
  );

  assign notify_desc_o = cur_idx;
  assign unused_top    = ^{eng_desc[6][FMT_BIT-1:0], eng_desc[7][WORD_W-1:PRIO_W]};
endmodule

// File: rtl/evq_enqueue_engine_chk.sv
module evq_enqueue_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trig_valid_i,
  input logic        trig_ready_o,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [59:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic        mem_err_i,
  input logic        notify_o,
  input logic        err_o
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

  assert_err_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !notify_o && !busy_o);

  assert_err_at_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> mem_req_o && mem_ack_i && mem_err_i);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(trig_valid_i && trig_ready_o));

  assert_notify_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |=> !busy_o && !notify_o);

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o && !trig_ready_o);
endmodule

bind evq_enqueue_engine evq_enqueue_engine_chk u_chk (.*);

// File: tb/evq_enqueue_engine_bench.sv
module evq_enqueue_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              trig_valid_i;
  logic              trig_ready_o;
  logic [IDX_W-1:0]  trig_desc_i;
  logic [31:0]       trig_data_i;
  logic              busy_o;
  logic              tbl_we_i;
  logic [IDX_W-1:0]  tbl_idx_i;
  logic [2:0]        tbl_word_i;
  logic [31:0]       tbl_wdata_i;
  logic [31:0]       tbl_rdata_o;
  logic              mem_req_o;
  logic [59:0]       mem_addr_o;
  logic [31:0]       mem_wdata_o;
  logic              mem_ack_i;
  logic              mem_err_i;
  logic              notify_o;
  logic [IDX_W-1:0]  notify_desc_o;
  logic              err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // results of the last trigger
  bit          saw_req, saw_ntf, saw_err, busy_first, hold_ok, ready_low;
  logic [59:0] req_addr;
  logic [31:0] req_data;
  logic [IDX_W-1:0] ntf_desc;
  int          n_ack, n_ntf;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_enqueue_engine u_evq_enqueue_engine (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input int idx, input int w, input logic [31:0] v);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_idx_i = IDX_W'(idx); tbl_word_i = 3'(w); tbl_wdata_i = v;
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  task automatic rd_word(input int idx, input int w, output logic [31:0] v);
    @(negedge clk);
    tbl_idx_i = IDX_W'(idx); tbl_word_i = 3'(w);
    #1 v = tbl_rdata_o;
  endtask

  task automatic load(input int idx, input logic [31:0] w0, w1, w2, w3, w6, w7);
    wr_word(idx, 0, w0); wr_word(idx, 1, w1); wr_word(idx, 2, w2);
    wr_word(idx, 3, w3); wr_word(idx, 6, w6); wr_word(idx, 7, w7);
  endtask

  // fire a trigger, answer the request after ack_delay waiting cycles,
  // optionally poke a second trigger while busy
  task automatic fire(input int idx, input logic [31:0] data, input int ack_delay,
                      input bit with_err, input int poke_idx);
    int held = 0;
    logic [59:0] prev_addr = '0;
    logic [31:0] prev_data = '0;
    saw_req = 0; saw_ntf = 0; saw_err = 0; busy_first = 0; hold_ok = 1;
    ready_low = 1; n_ack = 0; n_ntf = 0; ntf_desc = '0;
    @(negedge clk);
    trig_valid_i = 1'b1; trig_desc_i = IDX_W'(idx); trig_data_i = data;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      trig_valid_i = 1'b0; mem_ack_i = 1'b0; mem_err_i = 1'b0;
      if (c == 0) busy_first = busy_o;
      if (poke_idx >= 0 && c == 1) begin
        trig_valid_i = 1'b1; trig_desc_i = IDX_W'(poke_idx); trig_data_i = 32'h1;
        if (trig_ready_o) ready_low = 0;
      end
      if (mem_req_o) begin
        if (saw_req && (mem_addr_o !== prev_addr || mem_wdata_o !== prev_data)) hold_ok = 0;
        saw_req = 1; req_addr = mem_addr_o; req_data = mem_wdata_o;
        prev_addr = mem_addr_o; prev_data = mem_wdata_o;
        if (held == ack_delay) begin
          mem_ack_i = 1'b1; mem_err_i = with_err; n_ack++;
        end
        held++;
      end
      #1;
      if (err_o) saw_err = 1;
      if (notify_o) begin saw_ntf = 1; n_ntf++; ntf_desc = notify_desc_o; end
      if (!busy_o) break;
    end
    @(negedge clk);
    trig_valid_i = 1'b0; mem_ack_i = 1'b0; mem_err_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #1;
    chk("R12 ready", 64'(trig_ready_o), 64'd1);
    chk("R12 busy", 64'(busy_o), 64'd0);
    chk("R12 req", 64'(mem_req_o), 64'd0);
    chk("R12 notify", 64'(notify_o), 64'd0);
    rd_word(0, 0, v); chk("R12 desc0 word0", 64'(v), 64'd0);
    rd_word(5, 1, v); chk("R12 desc5 word1", 64'(v), 64'd0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    load(0, 32'hE000_0000, 32'h8000_0005, 32'hA000_0012, 32'h4000_1000, 32'h0, 32'h05);
    fire(0, 32'h8123_4567, 0, 0, -1);
    chk("R9 busy after accept", 64'(busy_first), 64'd1);
    chk("R1 address", 64'(req_addr), 64'h12_4000_1014);
    chk("R2 entry gen1", 64'(req_data), 64'h8123_4567);
    chk("R8 notify", 64'(saw_ntf), 64'd1);
    chk("R8 notify desc", 64'(ntf_desc), 64'd0);
    chk("R8 single pulse", 64'(n_ntf), 64'd1);
    rd_word(0, 1, v); chk("R3 index advance", 64'(v), 64'h8000_0006);
  endtask

  task automatic t_wrap_up();
    logic [31:0] v;
    load(1, 32'hE000_0001, 32'h7000_07FF, 32'h0, 32'h0001_0000, 32'h0, 32'h01);
    fire(1, 32'hDEAD_BEEF, 1, 0, -1);
    chk("R1 address qsize1", 64'(req_addr), 64'h1_1FFC);
    chk("R2 entry gen0", 64'(req_data), 64'h5EAD_BEEF);
    rd_word(1, 1, v); chk("R4 wrap sets gen, R3 keeps 30:28", 64'(v), 64'hF000_0000);
    fire(1, 32'h0000_0001, 0, 0, -1);
    chk("R1 address after wrap", 64'(req_addr), 64'h1_0000);
    chk("R2 entry new gen", 64'(req_data), 64'h8000_0001);
    rd_word(1, 1, v); chk("R3 index after wrap", 64'(v), 64'hF000_0001);
  endtask

  task automatic t_wrap_down_no_ntf();
    logic [31:0] v;
    load(2, 32'hC000_0000, 32'h8000_03FF, 32'h0, 32'h0, 32'h0, 32'h01);
    fire(2, 32'h0, 0, 0, -1);
    chk("R2 entry at last slot", 64'(req_data), 64'h8000_0000);
    rd_word(2, 1, v); chk("R4 wrap clears gen", 64'(v), 64'h0);
    chk("R8 notify flag clear", 64'(saw_ntf), 64'd0);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    load(3, 32'h6000_0000, 32'h0000_0042, 32'h0, 32'h0, 32'h0, 32'h01);
    fire(3, 32'h5, 0, 0, -1);
    chk("R5 no request", 64'(saw_req), 64'd0);
    chk("R5 no notify", 64'(saw_ntf), 64'd0);
    rd_word(3, 1, v); chk("R5 word1 unchanged", 64'(v), 64'h42);
  endtask

  task automatic t_no_enqueue();
    logic [31:0] v;
    load(4, 32'hA000_0000, 32'h0000_0010, 32'h0, 32'h0, 32'h0, 32'h03);
    fire(4, 32'h5, 0, 0, -1);
    chk("R6 no request", 64'(saw_req), 64'd0);
    chk("R6 notify still raised", 64'(saw_ntf), 64'd1);
    rd_word(4, 1, v); chk("R6 word1 unchanged", 64'(v), 64'h10);
  endtask

  task automatic t_mask();
    load(5, 32'hE000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFF);
    fire(5, 32'h9, 0, 0, -1);
    chk("R7 masked still writes", 64'(saw_req), 64'd1);
    chk("R7 masked no notify", 64'(saw_ntf), 64'd0);
    load(6, 32'hE000_0000, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'hFF);
    fire(6, 32'h9, 0, 0, -1);
    chk("R7 format set notifies", 64'(saw_ntf), 64'd1);
    chk("R7 notify desc", 64'(ntf_desc), 64'd6);
  endtask

  task automatic t_error();
    logic [31:0] v;
    fire(0, 32'h1234, 3, 1, -1);
    chk("R11 request held stable", 64'(hold_ok), 64'd1);
    chk("R10 err pulse", 64'(saw_err), 64'd1);
    chk("R10 no notify", 64'(saw_ntf), 64'd0);
    rd_word(0, 1, v); chk("R10 word1 unchanged", 64'(v), 64'h8000_0006);
  endtask

  task automatic t_busy_poke();
    logic [31:0] v;
    load(7, 32'hE000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h01);
    fire(6, 32'h2, 2, 0, 7);
    chk("R9 ready low while busy", 64'(ready_low), 64'd1);
    chk("R9 one request", 64'(n_ack), 64'd1);
    repeat (4) @(negedge clk);
    chk("R9 no late request", 64'(mem_req_o), 64'd0);
    rd_word(7, 1, v); chk("R9 poked desc unchanged", 64'(v), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trig_valid_i = 1'b0; trig_desc_i = '0; trig_data_i = '0;
    tbl_we_i = 1'b0; tbl_idx_i = '0; tbl_word_i = '0; tbl_wdata_i = '0;
    mem_ack_i = 1'b0; mem_err_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_wrap_up();
    t_wrap_down_no_ntf();
    t_invalid();
    t_no_enqueue();
    t_mask();
    t_error();
    t_busy_poke();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule